// File: doc/BRIEF.md
# Task-Based Memory Access Guard

This block watches every memory access a processor makes and raises a one-clock violation pulse when the running task touches a protected region it has no right to. Software picks the running task through a one-hot, 4-bit task register. The processor writes that register through an I/O write at a fixed port number.

A separate configuration port fills a protection table. The table holds one 4-bit deny mask for each 2 KB region of the protected span. In a mask, a set bit forbids the matching task and a clear bit grants it access.

Accesses outside the span from 800H to 7FFFFH are never checked. That covers the low vector area, the upper banks with the boot ROM and video memory, and the bank that holds the table itself. A task register that does not hold exactly one set bit is treated as untrusted, so every protected access made under it is flagged.

Top module: `task_guard`

## Requirements
- R1: After reset the task register holds 0001 (task 0) and every table mask is 0000, so no access is flagged.
- R2: An I/O write with io_addr equal to 60H loads io_wdata into the task register on the next clock edge; bit n of the register selects task n. An I/O write to any other port leaves the task register unchanged.
- R3: With exactly one task bit set, a protected access is flagged exactly when the mask bit of the addressed region at that same position is 1; for example, mask 1110 admits only task 0 and mask 0011 admits only tasks 2 and 3.
- R4: When the task register holds zero set bits or more than one set bit, every access inside the protected span is flagged, whatever the mask.
- R5: Only addresses from 800H through 7FFFFH inclusive are checked. Accesses at 7FFH or below, or at 80000H or above, never raise the violation output.
- R6: The region index is address bits [18:11], so each 2 KB region uses its own table entry, and entry 0 is never consulted.
- R7: A table write (tbl_we with tbl_idx and tbl_mask) is used by an access sampled on the next clock edge or later. An access sampled on the same edge as the write still sees the old mask.
- R8: violation is high for exactly the one cycle after the clock edge that samples an access with mem_rd or mem_wr high. Read strobes and write strobes are checked alike, and no violation is raised without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe from the processor |
| io_addr | input | 8 | I/O port number of the write |
| io_wdata | input | 4 | I/O write data (one-hot task select) |
| tbl_we | input | 1 | Protection table write enable |
| tbl_idx | input | 8 | Region index to write |
| tbl_mask | input | 4 | Deny mask to store (1 = task denied) |
| mem_addr | input | 20 | Address of the monitored access |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| violation | output | 1 | One-cycle pulse flagging a forbidden access |

## Verification
The bench builds the block with its default parameters: four tasks, a 20-bit address, 2 KB regions and a 256-entry table. It runs two full sweeps. The first tries all sixteen task-register values against all sixteen masks on one region, which covers every one-hot and every malformed selection. The second gives each of the 255 used regions its own mask and reads every one of them back through accesses. Fixed probes check the span edges at 7FFH, 800H, 7FFFFH and 80000H, a write and an access landing on the same edge, and a stray I/O port number.

// File: rtl/tg_pkg.sv
package tg_pkg;

  localparam int TG_NTASK = 4;
  localparam int TG_AW    = 20;
  localparam int TG_IOW   = 8;

  typedef logic [TG_NTASK-1:0] task_vec_t;

  // True when the selection holds exactly one set bit
  function automatic logic sel_is_onehot(task_vec_t sel);
    int n;
    n = 0;
    for (int i = 0; i < TG_NTASK; i++) n += int'(sel[i]);
    return (n == 1);
  endfunction

  // Deny decision: malformed selection denies everything
  function automatic logic deny_access(task_vec_t sel, task_vec_t mask);
    return !sel_is_onehot(sel) || (|(sel & mask));
  endfunction

  // Inclusive address window test
  function automatic logic addr_in_span(logic [TG_AW-1:0] a,
                                        logic [TG_AW-1:0] lo,
                                        logic [TG_AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/tg_task_reg.sv
module tg_task_reg #(
  parameter int NTASK = 4,
  parameter int IOW   = 8,
  parameter logic [IOW-1:0] PORT = 8'h60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [IOW-1:0]   io_addr,
  input  logic [NTASK-1:0] io_wdata,
  output logic [NTASK-1:0] task_q
);

  localparam logic [NTASK-1:0] RESET_SEL = {{(NTASK-1){1'b0}}, 1'b1};

  logic port_hit;
  assign port_hit = io_wr && (io_addr == PORT);

  always_ff @(posedge clk) begin
    if (!rst_n)        task_q <= RESET_SEL;
    else if (port_hit) task_q <= io_wdata;
  end

  // R2: register only changes through its own port
  assert_task_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && (io_addr == PORT)) |=> $stable(task_q));

endmodule

// File: rtl/tg_prot_table.sv
module tg_prot_table #(
  parameter int NTASK = 4,
  parameter int IDXW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDXW-1:0]  widx,
  input  logic [NTASK-1:0] wmask,
  input  logic [IDXW-1:0]  ridx,
  output logic [NTASK-1:0] rmask
);

  localparam int DEPTH = 1 << IDXW;

  logic [NTASK-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wmask;
    end
  end

  assign rmask = mem[ridx];

  // R7: written entry readable from the next cycle
  assert_tbl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(widx)] == $past(wmask)));

endmodule

// File: rtl/tg_region_decode.sv
module tg_region_decode #(
  parameter int AW    = 20,
  parameter int SHIFT = 11,
  parameter int IDXW  = 8,
  parameter logic [AW-1:0] SPAN_LO = 20'h00800,
  parameter logic [AW-1:0] SPAN_HI = 20'h7FFFF
) (
  input  logic [AW-1:0]   addr,
  output logic            in_span,
  output logic [IDXW-1:0] region
);

  import tg_pkg::*;

  assign in_span = addr_in_span(addr, SPAN_LO, SPAN_HI);
  assign region  = addr[SHIFT+IDXW-1:SHIFT];

  // R6: any checked address maps to a used entry
  always_comb begin
    if (in_span) assert_region_used_R6: assert (region != '0);
  end

endmodule

// File: rtl/task_guard.sv
module task_guard #(
  parameter int NTASK = tg_pkg::TG_NTASK,
  parameter int AW    = tg_pkg::TG_AW,
  parameter int IOW   = tg_pkg::TG_IOW,
  parameter int SHIFT = 11,
  parameter logic [IOW-1:0] TASK_PORT = 8'h60,
  parameter logic [AW-1:0]  SPAN_LO   = 20'h00800,
  parameter logic [AW-1:0]  SPAN_HI   = 20'h7FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [IOW-1:0]   io_addr,
  input  logic [NTASK-1:0] io_wdata,
  input  logic             tbl_we,
  input  logic [AW-SHIFT-2:0] tbl_idx,
  input  logic [NTASK-1:0] tbl_mask,
  input  logic [AW-1:0]    mem_addr,
  input  logic             mem_rd,
  input  logic             mem_wr,
  output logic             violation
);

  import tg_pkg::*;

  localparam int IDXW = AW - SHIFT - 1;

  logic [NTASK-1:0] cur_task;
  logic [NTASK-1:0] region_mask;
  logic [IDXW-1:0]  region;
  logic             in_span;
  logic             strobe;
  logic             task_ok;
  logic             deny;
  logic             viol_d;

  tg_task_reg #(.NTASK(NTASK), .IOW(IOW), .PORT(TASK_PORT)) u_task (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .task_q(cur_task));

  tg_region_decode #(.AW(AW), .SHIFT(SHIFT), .IDXW(IDXW),
                     .SPAN_LO(SPAN_LO), .SPAN_HI(SPAN_HI)) u_dec (
    .addr(mem_addr), .in_span(in_span), .region(region));

  tg_prot_table #(.NTASK(NTASK), .IDXW(IDXW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx),
    .wmask(tbl_mask), .ridx(region), .rmask(region_mask));

  assign strobe  = mem_rd || mem_wr;
  assign task_ok = sel_is_onehot(cur_task);
  assign deny    = deny_access(cur_task, region_mask);
  assign viol_d  = strobe && in_span && deny;

  always_ff @(posedge clk) begin
    if (!rst_n) violation <= 1'b0;
    else        violation <= viol_d;
  end

  // R8: a pulse always traces back to a strobe
  assert_pulse_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> $past(mem_rd || mem_wr));

  // R5: nothing outside the span is flagged
  assert_span_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> $past(in_span));

  // R4: malformed selection flags every checked access
  assert_bad_task_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && in_span && !task_ok) |=> violation);

  // R3: a granted one-hot task is never flagged
  assert_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (task_ok && ((cur_task & region_mask) == '0)) |=> !violation);

endmodule

// File: tb/task_guard_tb.sv
module task_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [3:0]  io_wdata = '0;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_idx = '0;
  logic [3:0]  tbl_mask = '0;
  logic [19:0] mem_addr = '0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic        violation;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  task_guard u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_mask(tbl_mask), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .violation(violation));

  function automatic bit model_flag(logic [3:0] t, logic [3:0] m, logic [19:0] a);
    bit inside_span;
    bit single;
    inside_span = (a >= 20'h00800) && (a <= 20'h7FFFF);
    single = (t == 4'b0001) || (t == 4'b0010) || (t == 4'b0100) || (t == 4'b1000);
    if (!inside_span) return 1'b0;
    if (!single) return 1'b1;
    return (t & m) != 4'b0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: violation=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_task(logic [7:0] port, logic [3:0] val);
    @(negedge clk);
    io_wr = 1'b1; io_addr = port; io_wdata = val;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic set_mask(logic [7:0] idx, logic [3:0] m);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_mask = m;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // one access; sample the pulse, then confirm it falls
  task automatic access(string req, logic [19:0] a, bit wr, bit exp);
    @(negedge clk);
    mem_addr = a; mem_rd = !wr; mem_wr = wr;
    @(negedge clk);
    mem_rd = 1'b0; mem_wr = 1'b0;
    check(req, violation, exp);
    @(negedge clk);
    check("R8", violation, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", violation, 1'b0);
    // R1: reset task 0 with empty masks is permitted everywhere
    access("R1", 20'h00800, 1'b0, 1'b0);
    access("R1", 20'h45678, 1'b1, 1'b0);

    // R8: no strobe, no pulse
    @(negedge clk);
    mem_addr = 20'h01000;
    @(negedge clk);
    check("R8", violation, 1'b0);

    // R3 / R4: every selection against every mask on region 5
    for (int t = 0; t < 16; t++) begin
      set_task(8'h60, 4'(t));
      for (int m = 0; m < 16; m++) begin
        set_mask(8'd5, 4'(m));
        access((t == 1 || t == 2 || t == 4 || t == 8) ? "R3" : "R4",
               20'h02800 + 20'(m), m[0], model_flag(4'(t), 4'(m), 20'h02800));
      end
    end

    // R3: document-style masks
    set_mask(8'd7, 4'b1110);
    set_task(8'h60, 4'b0001);
    access("R3", 20'h03800, 1'b0, 1'b0);
    set_task(8'h60, 4'b0010);
    access("R3", 20'h03800, 1'b1, 1'b1);
    set_mask(8'd7, 4'b0011);
    set_task(8'h60, 4'b0100);
    access("R3", 20'h03FFF, 1'b0, 1'b0);

    // R2: stray port ignored, task 2 still current
    set_task(8'h61, 4'b0001);
    access("R2", 20'h03800, 1'b0, 1'b0);
    set_task(8'h60, 4'b0001);
    access("R2", 20'h03800, 1'b0, 1'b1);

    // R5: span edges with a full-deny mask everywhere relevant
    set_mask(8'd1, 4'hF);
    set_mask(8'd255, 4'hF);
    set_mask(8'd0, 4'hF);
    access("R5", 20'h007FF, 1'b0, 1'b0);
    access("R5", 20'h00000, 1'b1, 1'b0);
    access("R5", 20'h00800, 1'b0, 1'b1);
    access("R5", 20'h7FFFF, 1'b1, 1'b1);
    access("R5", 20'h80000, 1'b0, 1'b0);
    access("R5", 20'hFFFFF, 1'b1, 1'b0);
    access("R5", 20'hC0800, 1'b0, 1'b0);

    // R6: every used region carries its own mask, task 2 selected
    set_task(8'h60, 4'b0100);
    for (int k = 1; k < 256; k++) set_mask(8'(k), 4'(k ^ (k >> 4)));
    for (int k = 1; k < 256; k++) begin
      logic [3:0] m;
      m = 4'(k ^ (k >> 4));
      access("R6", 20'(k) << 11 | 20'h00123, k[0], m[2]);
    end

    // R7: write and access on the same edge sees the old mask
    set_task(8'h60, 4'b1000);
    set_mask(8'd9, 4'h0);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 8'd9; tbl_mask = 4'hF;
    mem_addr = 20'h04800; mem_rd = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0;
    check("R7", violation, 1'b0);
    @(negedge clk);
    mem_rd = 1'b0;
    check("R7", violation, 1'b1);
    @(negedge clk);
    check("R8", violation, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule